// File: doc/BRIEF.md
# Barrel Shift and Bitfield Unit

A 32-bit execution unit for a soft processor pipeline. Each strobed operation is one of three kinds: a plain shift of operand A by the low five bits of operand B, a bitfield extract from operand A, or a bitfield insert of operand A's low bits into the current destination value. The plain shift can be left, right logical or right arithmetic. The decoder reads the mode from a 16-bit immediate. The extract and insert modes exist only in the immediate instruction form.

Each bitfield mode has its own rule for inputs whose result is undefined. Such inputs raise an invalid flag and block the register write. When the unit is not present in the configuration, exceptions are enabled and illegal-opcode trapping is configured, the unit requests an illegal-opcode exception and does not write. All outputs are registered, so the result appears one cycle after the strobe.

Top module: `bfx_shift_unit`

## Requirements
- R1: In register form (`imm_form`=0), immediate bits 15 and 14 are ignored and the operation is a plain shift.
- R2: For a plain shift, immediate bit 10 set gives a left shift. With bit 10 clear, bit 9 set gives an arithmetic right shift and bit 9 clear gives a logical right shift.
- R3: The shift distance is `opnd_b[4:0]`. Higher bits of operand B have no effect.
- R4: Extract (immediate form, bit 14 set) takes W bits of operand A starting at bit S and returns them in the low bits of the result, with all upper bits zero. W is immediate bits 10:6 and S is immediate bits 4:0.
- R5: An extract with W=0, or with W+S>32, is invalid.
- R6: Insert (immediate form, bit 15 set) writes the low W-S+1 bits of operand A into destination bits W down to S. All other destination bits keep their value.
- R7: An insert with W<S is invalid.
- R8: For an invalid input, `bad_input` is 1, `res_we` is 0 and `result` equals the destination value that was presented.
- R9: `illop_req` is 1 only when the unit is absent, `exc_enable`=1 and `illop_cfg`=1. In that case `res_we` is 0 and `result` equals the destination value. When the unit is absent but trapping is off, the operation executes normally.
- R10: Extract has priority over insert, and insert has priority over the plain shift.
- R11: Outputs update one cycle after an `in_valid` strobe. In a cycle with no strobe, `res_we`, `bad_input` and `illop_req` are all 0. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| opnd_a | input | 32 | Source operand A |
| opnd_b | input | 32 | Operand B (register or immediate value) |
| dest_cur | input | 32 | Current destination register value |
| imm | input | 16 | Instruction immediate field |
| imm_form | input | 1 | 1 = immediate instruction form |
| unit_present | input | 1 | Unit is configured as present |
| exc_enable | input | 1 | Exceptions enabled |
| illop_cfg | input | 1 | Illegal-opcode exceptions configured |
| result | output | 32 | Registered result |
| res_we | output | 1 | Destination write enable |
| bad_input | output | 1 | Undefined bitfield input detected |
| illop_req | output | 1 | Illegal-opcode exception request |

## Verification
The assertions are checked on every cycle. They cover the following:
- at most one of write, invalid and exception is raised at a time;
- flags stay quiet in cycles after no strobe;
- the exception and invalid paths never write, and return the presented destination value;
- the register form never reports invalid;
- an extract result has nothing above its field;
- an insert leaves the destination bits below its start position untouched.

Only the bench scenarios can show the exact values produced by each shift kind and bitfield placement. The same holds for where the validity boundaries fall and for the extract-over-insert priority. Those scenarios are compared against the bench's own bit-by-bit model.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  // immediate bit positions decoded by the unit
  localparam int unsigned IMM_INS_BIT   = 15;
  localparam int unsigned IMM_EXT_BIT   = 14;
  localparam int unsigned IMM_LEFT_BIT  = 10;
  localparam int unsigned IMM_ARITH_BIT = 9;
  localparam int unsigned IMM_W_LO      = 6;
  localparam int unsigned IMM_S_LO      = 0;

  typedef enum logic [1:0] {
    OP_SHIFT   = 2'd0,
    OP_INSERT  = 2'd1,
    OP_EXTRACT = 2'd2
  } bfx_op_e;
endpackage

// File: rtl/bfx_shifter.sv
module bfx_shifter #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  amt,
  input  logic            left,
  input  logic            arith,
  output logic [XLEN-1:0] dout
);
  function automatic logic [XLEN-1:0] bit_rev(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
    return r;
  endfunction

  logic            fill;
  logic [XLEN-1:0] stage [SHW+1];

  assign fill     = arith & ~left & din[XLEN-1];
  assign stage[0] = left ? bit_rev(din) : din;

  // logarithmic right-shift stages; left shift is done by mirroring
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int unsigned D = 1 << k;
    assign stage[k+1] = amt[k] ? {{D{fill}}, stage[k][XLEN-1:D]} : stage[k];
  end

  assign dout = left ? bit_rev(stage[SHW]) : stage[SHW];
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned FW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] src,
  input  logic [FW-1:0]   wid,
  input  logic [FW-1:0]   pos,
  output logic [XLEN-1:0] field,
  output logic            undef
);
  localparam logic [FW:0] LIMIT = XLEN[FW:0];

  function automatic logic [XLEN-1:0] low_ones(input logic [FW:0] n);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  logic [XLEN-1:0] aligned;
  logic [FW:0]     span;

  bfx_shifter #(.XLEN(XLEN)) u_align (
    .din  (src),
    .amt  (pos),
    .left (1'b0),
    .arith(1'b0),
    .dout (aligned)
  );

  assign span  = {1'b0, wid} + {1'b0, pos};
  assign undef = (wid == '0) || (span > LIMIT);
  assign field = aligned & low_ones({1'b0, wid});
endmodule

// File: rtl/bfx_insert.sv
module bfx_insert #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned FW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] dest,
  input  logic [FW-1:0]   top,
  input  logic [FW-1:0]   pos,
  output logic [XLEN-1:0] merged,
  output logic            undef
);
  function automatic logic [XLEN-1:0] low_ones(input logic [FW:0] n);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  logic [XLEN-1:0] placed;
  logic [XLEN-1:0] span_mask;

  bfx_shifter #(.XLEN(XLEN)) u_place (
    .din  (src),
    .amt  (pos),
    .left (1'b1),
    .arith(1'b0),
    .dout (placed)
  );

  // bits pos..top inclusive
  assign span_mask = low_ones({1'b0, top} + 1'b1) & ~low_ones({1'b0, pos});
  assign undef     = top < pos;
  assign merged    = (dest & ~span_mask) | (placed & span_mask);
endmodule

// File: rtl/bfx_shift_unit.sv
module bfx_shift_unit
  import bfx_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IMMW = 16,
  localparam int unsigned FW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [XLEN-1:0] dest_cur,
  input  logic [IMMW-1:0] imm,
  input  logic            imm_form,
  input  logic            unit_present,
  input  logic            exc_enable,
  input  logic            illop_cfg,
  output logic [XLEN-1:0] result,
  output logic            res_we,
  output logic            bad_input,
  output logic            illop_req
);
  // named decode events
  logic            trap_now;
  logic            ext_sel;
  logic            ins_sel;
  bfx_op_e         op_sel;
  logic [FW-1:0]   fld_w;
  logic [FW-1:0]   fld_s;

  assign trap_now = ~unit_present & exc_enable & illop_cfg;
  assign ext_sel  = imm_form & imm[IMM_EXT_BIT];
  assign ins_sel  = imm_form & imm[IMM_INS_BIT] & ~ext_sel;
  assign fld_w    = imm[IMM_W_LO +: FW];
  assign fld_s    = imm[IMM_S_LO +: FW];

  always_comb begin
    if (ext_sel)      op_sel = OP_EXTRACT;
    else if (ins_sel) op_sel = OP_INSERT;
    else              op_sel = OP_SHIFT;
  end

  logic [XLEN-1:0] sh_out, ex_out, in_out;
  logic            ex_undef, in_undef;

  bfx_shifter #(.XLEN(XLEN)) u_shift (
    .din  (opnd_a),
    .amt  (opnd_b[FW-1:0]),
    .left (imm[IMM_LEFT_BIT]),
    .arith(imm[IMM_ARITH_BIT]),
    .dout (sh_out)
  );

  bfx_extract #(.XLEN(XLEN)) u_ext (
    .src  (opnd_a),
    .wid  (fld_w),
    .pos  (fld_s),
    .field(ex_out),
    .undef(ex_undef)
  );

  bfx_insert #(.XLEN(XLEN)) u_ins (
    .src   (opnd_a),
    .dest  (dest_cur),
    .top   (fld_w),
    .pos   (fld_s),
    .merged(in_out),
    .undef (in_undef)
  );

  logic [XLEN-1:0] op_val;
  logic            op_undef;

  always_comb begin
    unique case (op_sel)
      OP_EXTRACT: begin op_val = ex_out; op_undef = ex_undef; end
      OP_INSERT:  begin op_val = in_out; op_undef = in_undef; end
      default:    begin op_val = sh_out; op_undef = 1'b0;     end
    endcase
  end

  logic            nxt_we, nxt_bad, nxt_trap;
  logic [XLEN-1:0] nxt_res;

  always_comb begin
    nxt_trap = trap_now;
    nxt_bad  = ~trap_now & op_undef;
    nxt_we   = ~trap_now & ~op_undef;
    nxt_res  = nxt_we ? op_val : dest_cur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      res_we    <= 1'b0;
      bad_input <= 1'b0;
      illop_req <= 1'b0;
    end else begin
      res_we    <= in_valid & nxt_we;
      bad_input <= in_valid & nxt_bad;
      illop_req <= in_valid & nxt_trap;
      if (in_valid) result <= nxt_res;
    end
  end
endmodule

// File: rtl/bfx_shift_unit_chk.sv
module bfx_shift_unit_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IMMW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [XLEN-1:0] dest_cur,
  input logic [IMMW-1:0] imm,
  input logic            imm_form,
  input logic            unit_present,
  input logic            exc_enable,
  input logic            illop_cfg,
  input logic [XLEN-1:0] result,
  input logic            res_we,
  input logic            bad_input,
  input logic            illop_req,
  input logic            ext_sel,
  input logic            ins_sel
);
  logic gate_on;
  assign gate_on = ~unit_present & exc_enable & illop_cfg;

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_we, bad_input, illop_req}));

  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_we && !bad_input && !illop_req));

  a_r9_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gate_on) |=> (illop_req && !res_we && result == $past(dest_cur)));

  a_r8_invalid_keeps_dest: assert property (@(posedge clk) disable iff (!rst_n)
    bad_input |-> (!res_we && result == $past(dest_cur)));

  a_r1_regform_never_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !imm_form) |=> !bad_input);

  a_r4_extract_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ext_sel) |=> (!res_we || (result >> $past(imm[10:6])) == '0));

  a_r6_insert_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ins_sel) |=>
      (!res_we || ((result ^ $past(dest_cur)) << (XLEN - $past(imm[4:0]))) == '0));
endmodule

bind bfx_shift_unit bfx_shift_unit_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dest_cur(dest_cur),
  .imm(imm), .imm_form(imm_form), .unit_present(unit_present),
  .exc_enable(exc_enable), .illop_cfg(illop_cfg), .result(result),
  .res_we(res_we), .bad_input(bad_input), .illop_req(illop_req),
  .ext_sel(ext_sel), .ins_sel(ins_sel)
);

// File: tb/bfx_shift_unit_tb.sv
module bfx_shift_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, dest_cur = '0;
  logic [15:0] imm = '0;
  logic        imm_form = 1'b0;
  logic        unit_present = 1'b1, exc_enable = 1'b0, illop_cfg = 1'b0;
  logic [31:0] result;
  logic        res_we, bad_input, illop_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bfx_shift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .dest_cur(dest_cur), .imm(imm), .imm_form(imm_form),
    .unit_present(unit_present), .exc_enable(exc_enable), .illop_cfg(illop_cfg),
    .result(result), .res_we(res_we), .bad_input(bad_input), .illop_req(illop_req)
  );

  typedef struct packed {
    logic        form;
    logic [15:0] imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] d;
  } vec_t;

  // imm: [15]=insert [14]=extract [10:6]=W [4:0]=S; [10]=left [9]=arith
  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{1'b0, 16'h0400, 32'h0000_00F1, 32'h0000_0024, 32'h1111_1111}, // R2 R3 left
    '{1'b0, 16'h0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1111_1111}, // R2 logical right 31
    '{1'b0, 16'h0200, 32'h8000_0000, 32'h0000_0004, 32'h1111_1111}, // R2 arith right
    '{1'b0, 16'h0200, 32'h4000_0000, 32'h0000_0002, 32'h1111_1111}, // R2 arith positive
    '{1'b0, 16'hC000, 32'h1234_5678, 32'h0000_0008, 32'h1111_1111}, // R1 reg form
    '{1'b0, 16'h8123, 32'h1234_5678, 32'h0000_0004, 32'h1111_1111}, // R1 reg form ins bit
    '{1'b1, 16'h0403, 32'h0000_0001, 32'h0000_0003, 32'h1111_1111}, // R2 imm shift
    '{1'b1, 16'h4204, 32'h0000_0AB0, 32'h0000_0000, 32'h1111_1111}, // R4 W8 S4
    '{1'b1, 16'h47C1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1111_1111}, // R4 W31 S1 edge
    '{1'b1, 16'h4005, 32'hFFFF_FFFF, 32'h0000_0000, 32'h2222_2222}, // R5 W0
    '{1'b1, 16'h4514, 32'hFFFF_FFFF, 32'h0000_0000, 32'h3333_3333}, // R5 W20 S20
    '{1'b1, 16'h82C4, 32'h0000_00CD, 32'h0000_0000, 32'hFFFF_FFFF}, // R6 W11 S4
    '{1'b1, 16'h80C5, 32'h0000_00CD, 32'h0000_0000, 32'h4444_4444}, // R7 W3 S5
    '{1'b1, 16'hC100, 32'h0000_005A, 32'h0000_0000, 32'hFFFF_FFFF}  // R10 both bits
  };

  // independent model: {we, bad, result}
  function automatic logic [33:0] model(input vec_t v);
    logic [31:0] r;
    int w, s;
    w = int'(v.imm[10:6]);
    s = int'(v.imm[4:0]);
    r = '0;
    if (v.form && v.imm[14]) begin
      if (w == 0 || w + s > 32) return {1'b0, 1'b1, v.d};
      for (int i = 0; i < w; i++) r[i] = v.a[s + i];
      return {1'b1, 1'b0, r};
    end
    if (v.form && v.imm[15]) begin
      if (w < s) return {1'b0, 1'b1, v.d};
      r = v.d;
      for (int i = s; i <= w; i++) r[i] = v.a[i - s];
      return {1'b1, 1'b0, r};
    end
    if (v.imm[10])     r = v.a << v.b[4:0];
    else if (v.imm[9]) r = $unsigned($signed(v.a) >>> v.b[4:0]);
    else               r = v.a >> v.b[4:0];
    return {1'b1, 1'b0, r};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    imm_form = v.form; imm = v.imm; opnd_a = v.a; opnd_b = v.b; dest_cur = v.d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [33:0] e;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset result", result, 32'h0);
    check("R11 reset flags", {29'd0, res_we, bad_input, illop_req}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VT[i]);
      e = model(VT[i]);
      check($sformatf("R1-10 vec%0d result", i), result, e[31:0]);
      check($sformatf("R8 vec%0d we/bad", i), {30'd0, res_we, bad_input}, {30'd0, e[33:32]});
    end

    // R3 and R2: upper B bits ignored, left shift
    apply('{1'b0, 16'h0400, 32'h0000_0003, 32'hFFFF_FFE1, 32'h0});
    check("R3 amount masked", result, 32'h0000_0006);
    // R4 exact value: W8 S4 of 0xAB0
    apply('{1'b1, 16'h4204, 32'hFFFF_FAB0, 32'h0, 32'h0});
    check("R4 extract value", result, 32'h0000_00AB);
    // R6 exact insert value
    apply('{1'b1, 16'h82C4, 32'h0000_00CD, 32'h0, 32'hFFFF_FFFF});
    check("R6 insert value", result, 32'hFFFF_FCDF);
    // R8 invalid keeps dest
    apply('{1'b1, 16'h4514, 32'hFFFF_FFFF, 32'h0, 32'h3333_3333});
    check("R8 invalid result=dest", result, 32'h3333_3333);
    check("R5 invalid flag", {31'd0, bad_input}, 32'd1);
    // R10 extract beats insert: W4 S0 of 0x5A
    apply('{1'b1, 16'hC100, 32'h0000_005A, 32'h0, 32'hFFFF_FFFF});
    check("R10 extract priority", result, 32'h0000_000A);
    // R11 no strobe next cycle: flags low
    @(negedge clk);
    check("R11 idle flags", {29'd0, res_we, bad_input, illop_req}, 32'h0);
    check("R11 idle result held", result, 32'h0000_000A);

    // R9 trap
    unit_present = 1'b0; exc_enable = 1'b1; illop_cfg = 1'b1;
    apply('{1'b0, 16'h0400, 32'h1, 32'h1, 32'h5555_AAAA});
    check("R9 trap flags", {29'd0, res_we, bad_input, illop_req}, 32'h1);
    check("R9 trap result=dest", result, 32'h5555_AAAA);
    // R9 trap overrides invalid as well
    apply('{1'b1, 16'h4005, 32'h1, 32'h0, 32'h7777_7777});
    check("R9 trap over invalid", {29'd0, res_we, bad_input, illop_req}, 32'h1);
    // R9 absent but trap config off: executes
    illop_cfg = 1'b0;
    apply('{1'b0, 16'h0400, 32'h1, 32'h4, 32'h0});
    check("R9 no trap executes", result, 32'h0000_0010);
    check("R9 no trap flags", {29'd0, res_we, bad_input, illop_req}, 32'h4);
    illop_cfg = 1'b1; exc_enable = 1'b0;
    apply('{1'b0, 16'h0000, 32'h80, 32'h7, 32'h0});
    check("R9 exc disabled executes", result, 32'h0000_0001);
    unit_present = 1'b1; exc_enable = 1'b1;
    apply('{1'b0, 16'h0200, 32'hF000_0000, 32'h1C, 32'h0});
    check("R9 present no trap", {29'd0, res_we, bad_input, illop_req}, 32'h4);
    check("R2 arith by 28", result, 32'hFFFF_FFFF);

    // reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset again", result, 32'h0);
    finish_run();
  end
endmodule